// File: doc/BRIEF.md
# EDH Flag Monitor

This block sits on a 10-bit parallel SD video word stream. It looks for error detection and handling (EDH) ancillary packets. Each packet carries three 5-bit flag groups: full field, active picture and ancillary. The block captures the groups, keeps them in status registers and derives a flag-error bit for each group and one overall EDH-error bit. It also passes the word stream through with one cycle of latency. While the force control is high, it rewrites the flag words of every EDH packet with freshly generated clean flags and recomputes the packet checksum to match.

The packet opens with the ancillary flag words 000h, 3FFh, 3FFh, followed by the data ID 1F4h. Counting from the word after the data ID, the words are: data block number (0), data count (1), sixteen payload words (2..17) and the checksum (18). The ancillary, active-picture and full-field flag words are payload words 6, 7 and 8. Flags are held in a shadow copy while the packet arrives. They are committed only when the checksum word is accepted, so stored values change only on complete packets.

Top module: `edh_flag_monitor`

## Requirements
- R1: After reset, all stored flags, all error outputs, `valid_o` and `data_o` are zero.
- R2: A packet is recognised only when the data ID 1F4h directly follows the words 000h, 3FFh, 3FFh. A lone 1F4h starts no packet and changes no flag.
- R3: Each flag group comes from bits 6..2 of its flag word, which are words 8 (ancillary), 9 (active picture) and 10 (full field) after the data ID. Within a group, bit 0 is EDH, bit 1 EDA, bit 2 IDH, bit 3 IDA and bit 4 UES.
- R4: Stored flags change only on the clock edge that accepts the checksum word (word 18 after the data ID), and are visible from the next cycle. Before that word they keep their old values.
- R5: A packet that holds a 000h or 3FFh word before its checksum is dropped, and the stored flags keep their previous values.
- R6: Flags are committed only if `en_i` was high for every word from the data ID through the checksum. Otherwise the stored flags are unchanged.
- R7: Each group error output is the OR of that group's EDH and EDA bits. IDH, IDA and UES do not set it.
- R8: `edh_err_o` is high exactly when any of the 15 stored flag bits is set.
- R9: While `force_i` is high, the three flag words of an EDH packet leave as 200h (no flags, with parity bits), whatever arrived.
- R10: While `force_i` is high, the checksum word is replaced by {~s[8], s}, where s is the 9-bit sum of bits 8..0 of the outgoing words from the data ID through payload word 17. With `force_i` low, the checksum passes unchanged.
- R11: Every word is presented on `data_o`, with `valid_o` high, one clock after it is sampled with `valid_i` high. Apart from the R9/R10 rewrites the word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Flag capture enable |
| force_i | input | 1 | Rewrite flags and checksum on output |
| valid_i | input | 1 | Input word strobe |
| data_i | input | 10 | Input video word |
| valid_o | output | 1 | Output word strobe |
| data_o | output | 10 | Output video word |
| ff_flags_o | output | 5 | Stored full-field flags |
| ap_flags_o | output | 5 | Stored active-picture flags |
| anc_flags_o | output | 5 | Stored ancillary flags |
| ff_err_o | output | 1 | Full-field EDH or EDA set |
| ap_err_o | output | 1 | Active-picture EDH or EDA set |
| anc_err_o | output | 1 | Ancillary EDH or EDA set |
| edh_err_o | output | 1 | Any stored flag set |

## Verification
The output word and its strobe are due one cycle after the input word. Stored flags and the error bits derived from them are due one cycle after the checksum word is sampled. The bench drives each word on a falling edge, so the rising edge in between samples it. It reads results on the next falling edge. A monitor records every output word on falling edges, and forced packets are checked word by word against a stream rebuilt in the bench. Flags are read once just before the checksum word and again after it, which shows the commit point.

// File: rtl/edh_pkg.sv
package edh_pkg;
  localparam int WORD_W    = 10;
  localparam int GRP_W     = 5;
  localparam int N_GRP     = 3;   // 0 anc, 1 ap, 2 ff
  localparam int IDX_W     = 5;
  localparam int FLAG_LSB  = 2;
  localparam int IDX_FLAG0 = 8;   // ancillary flag word index after DID
  localparam int IDX_CS    = 18;  // checksum word index after DID
  localparam int SUM_W     = WORD_W - 1;
  localparam logic [WORD_W-1:0] ADF_LO     = 10'h000;
  localparam logic [WORD_W-1:0] ADF_HI     = 10'h3FF;
  localparam logic [WORD_W-1:0] DID_EDH    = 10'h1F4;
  localparam logic [WORD_W-1:0] CLEAN_FLAG = 10'h200;
  typedef logic [GRP_W-1:0] grp_t;
endpackage

// File: rtl/edh_pkt_track.sv
module edh_pkt_track
  import edh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              start_o,
  output logic              in_pkt_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [1:0]       adf_q;
  logic             in_q;
  logic [IDX_W-1:0] idx_q;
  logic             legal;

  assign legal    = (data_i != ADF_LO) && (data_i != ADF_HI);
  assign start_o  = valid_i && !in_q && (adf_q == 2'd3) && (data_i == DID_EDH);
  assign in_pkt_o = valid_i && in_q && legal;
  assign last_o   = in_pkt_o && (idx_q == IDX_W'(IDX_CS));
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adf_q <= '0;
      in_q  <= 1'b0;
      idx_q <= '0;
    end else if (valid_i) begin
      if (in_q) begin
        if (!legal) begin
          in_q  <= 1'b0;
          adf_q <= (data_i == ADF_LO) ? 2'd1 : 2'd0;
        end else if (idx_q == IDX_W'(IDX_CS)) begin
          in_q  <= 1'b0;
          adf_q <= 2'd0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (data_i == ADF_LO) begin
        adf_q <= 2'd1;
      end else if (data_i == ADF_HI && (adf_q == 2'd1 || adf_q == 2'd2)) begin
        adf_q <= adf_q + 2'd1;
      end else if (start_o) begin
        in_q  <= 1'b1;
        idx_q <= '0;
        adf_q <= 2'd0;
      end else begin
        adf_q <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/edh_flag_store.sv
module edh_flag_store
  import edh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              in_pkt_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  output grp_t              flags_o [N_GRP],
  output logic [N_GRP-1:0]  grp_err_o,
  output logic              any_err_o
);
  logic ok_q;
  grp_t shadow_q [N_GRP];
  grp_t store_q  [N_GRP];
  logic [N_GRP-1:0] grp_any;

  // enable must hold for the whole packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ok_q <= 1'b0;
    else if (start_i)            ok_q <= en_i;
    else if (in_pkt_i && !en_i)  ok_q <= 1'b0;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        store_q[g]  <= '0;
      end else begin
        if (in_pkt_i && idx_i == IDX_W'(IDX_FLAG0 + g))
          shadow_q[g] <= data_i[FLAG_LSB +: GRP_W];
        if (last_i && en_i && ok_q)
          store_q[g] <= shadow_q[g];
      end
    end
    assign flags_o[g]   = store_q[g];
    assign grp_err_o[g] = store_q[g][0] | store_q[g][1];
    assign grp_any[g]   = |store_q[g];
  end

  assign any_err_o = |grp_any;
endmodule

// File: rtl/edh_out_rewrite.sv
module edh_out_rewrite
  import edh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              start_i,
  input  logic              in_pkt_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  logic [SUM_W-1:0]  sum_q;
  logic [WORD_W-1:0] word;
  logic              is_flag;

  assign is_flag = in_pkt_i && (idx_i >= IDX_W'(IDX_FLAG0)) &&
                   (idx_i < IDX_W'(IDX_FLAG0 + N_GRP));

  always_comb begin
    word = data_i;
    if (force_i && is_flag) word = CLEAN_FLAG;
    else if (force_i && last_i) word = {~sum_q[SUM_W-1], sum_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= word;
      if (start_i) sum_q <= data_i[SUM_W-1:0];
      else if (in_pkt_i && !last_i) sum_q <= sum_q + word[SUM_W-1:0];
    end
  end
endmodule

// File: rtl/edh_flag_monitor.sv
module edh_flag_monitor
  import edh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              force_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic [GRP_W-1:0]  ff_flags_o,
  output logic [GRP_W-1:0]  ap_flags_o,
  output logic [GRP_W-1:0]  anc_flags_o,
  output logic              ff_err_o,
  output logic              ap_err_o,
  output logic              anc_err_o,
  output logic              edh_err_o
);
  logic             start, in_pkt, last;
  logic [IDX_W-1:0] idx;
  grp_t             flags [N_GRP];
  logic [N_GRP-1:0] grp_err;

  edh_pkt_track u_track (
    .clk_i, .rst_ni, .valid_i, .data_i,
    .start_o(start), .in_pkt_o(in_pkt), .last_o(last), .idx_o(idx)
  );

  edh_flag_store u_store (
    .clk_i, .rst_ni, .en_i, .start_i(start), .in_pkt_i(in_pkt),
    .last_i(last), .idx_i(idx), .data_i,
    .flags_o(flags), .grp_err_o(grp_err), .any_err_o(edh_err_o)
  );

  edh_out_rewrite u_out (
    .clk_i, .rst_ni, .force_i, .valid_i, .data_i, .start_i(start),
    .in_pkt_i(in_pkt), .last_i(last), .idx_i(idx), .valid_o, .data_o
  );

  assign anc_flags_o = flags[0];
  assign ap_flags_o  = flags[1];
  assign ff_flags_o  = flags[2];
  assign anc_err_o   = grp_err[0];
  assign ap_err_o    = grp_err[1];
  assign ff_err_o    = grp_err[2];
endmodule

// File: rtl/edh_flag_monitor_chk.sv
module edh_flag_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       force_i,
  input logic       valid_i,
  input logic [9:0] data_i,
  input logic       valid_o,
  input logic [9:0] data_o,
  input logic [4:0] ff_flags_o,
  input logic [4:0] ap_flags_o,
  input logic [4:0] anc_flags_o,
  input logic       edh_err_o
);
  logic [14:0] all_flags;
  assign all_flags = {ff_flags_o, ap_flags_o, anc_flags_o};

  a_r11_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r11_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !force_i) |=> data_o == $past(data_i));
  a_r4_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(all_flags));
  a_r5_ctrl_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (data_i == 10'h000 || data_i == 10'h3FF)) |=> $stable(all_flags));
  a_r6_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(all_flags));
  a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(edh_err_o) |-> all_flags == '0);
endmodule

bind edh_flag_monitor edh_flag_monitor_chk u_chk (
  .clk_i, .rst_ni, .en_i, .force_i, .valid_i, .data_i, .valid_o, .data_o,
  .ff_flags_o, .ap_flags_o, .anc_flags_o, .edh_err_o
);

// File: tb/edh_flag_monitor_test.sv
`timescale 1ns/1ps
module edh_flag_monitor_test;
  logic clk_i = 0, rst_ni = 0, en_i = 1, force_i = 0, valid_i = 0;
  logic [9:0] data_i = '0;
  logic valid_o; logic [9:0] data_o;
  logic [4:0] ff_flags_o, ap_flags_o, anc_flags_o;
  logic ff_err_o, ap_err_o, anc_err_o, edh_err_o;
  int total = 0, bad = 0;
  logic [9:0] ob [1024];
  int on = 0;
  logic [9:0] pk [23];
  logic [9:0] exp_cs;

  always #10 clk_i = ~clk_i;

  edh_flag_monitor uut (.*);

  always @(negedge clk_i) if (valid_o) begin ob[on % 1024] = data_o; on++; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] fw(logic [4:0] f);
    logic [7:0] w = {1'b0, f, 2'b00};
    return {~(^w), ^w, w};
  endfunction

  function automatic logic [9:0] csum(int upto);
    logic [8:0] s = '0;
    for (int k = 3; k < upto; k++) s += pk[k][8:0];
    return {~s[8], s};
  endfunction

  // packet words 0..22: ADF 0..2, DID 3, DBN 4, DC 5, payload 6..21, CS 22
  task automatic build(logic [4:0] anc, logic [4:0] ap, logic [4:0] ff);
    pk[0] = 10'h000; pk[1] = 10'h3FF; pk[2] = 10'h3FF; pk[3] = 10'h1F4;
    pk[4] = 10'h200; pk[5] = 10'h110;
    for (int k = 6; k < 22; k++) pk[k] = (k < 12) ? 10'h2AA : 10'h200;
    pk[12] = fw(anc); pk[13] = fw(ap); pk[14] = fw(ff);
    pk[22] = csum(22);
  endtask

  task automatic word(logic [9:0] w);
    @(negedge clk_i); data_i = w; valid_i = 1;
  endtask

  task automatic idle(int n);
    @(negedge clk_i); valid_i = 0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send(int first, int upto);
    for (int k = first; k < upto; k++) word(pk[k]);
  endtask

  task automatic flags_are(string req, logic [4:0] anc, logic [4:0] ap, logic [4:0] ff);
    chk(req, anc_flags_o, anc); chk(req, ap_flags_o, ap); chk(req, ff_flags_o, ff);
  endtask

  task automatic t_reset;
    chk("R1 flags", {ff_flags_o, ap_flags_o, anc_flags_o}, 0);
    chk("R1 errs", {ff_err_o, ap_err_o, anc_err_o, edh_err_o}, 0);
    chk("R1 out", {valid_o, data_o}, 0);
  endtask

  task automatic t_basic;
    build(5'h01, 5'h02, 5'h10);
    send(0, 22);
    @(negedge clk_i);
    flags_are("R4 before checksum", 0, 0, 0);
    data_i = pk[22]; valid_i = 1;
    @(negedge clk_i); valid_i = 0;
    flags_are("R3 R4 capture", 5'h01, 5'h02, 5'h10);
    chk("R7 anc EDH", anc_err_o, 1); chk("R7 ap EDA", ap_err_o, 1);
    chk("R7 ff UES only", ff_err_o, 0); chk("R8 any", edh_err_o, 1);
    idle(2);
  endtask

  task automatic t_no_adf;
    build(5'h1F, 5'h1F, 5'h1F);
    send(3, 23); idle(2);
    flags_are("R2 lone DID", 5'h01, 5'h02, 5'h10);
  endtask

  task automatic t_trunc;
    build(5'h03, 5'h03, 5'h03);
    send(0, 16); word(10'h3FF); send(16, 23); idle(2);
    flags_are("R5 truncated", 5'h01, 5'h02, 5'h10);
  endtask

  task automatic t_disable;
    build(5'h07, 5'h07, 5'h07);
    en_i = 0; send(0, 23); idle(2); en_i = 1;
    flags_are("R6 disabled", 5'h01, 5'h02, 5'h10);
    send(0, 10); @(negedge clk_i); en_i = 0; @(negedge clk_i); en_i = 1;
    send(10, 23); idle(2);
    flags_are("R6 drop mid packet", 5'h01, 5'h02, 5'h10);
  endtask

  task automatic t_summary;
    build(5'h04, 5'h08, 5'h1C);
    send(0, 23); idle(2);
    flags_are("R3 upper bits", 5'h04, 5'h08, 5'h1C);
    chk("R7 IDH/IDA/UES ignored", {ff_err_o, ap_err_o, anc_err_o}, 0);
    chk("R8 set by IDH", edh_err_o, 1);
    build(0, 0, 0);
    send(0, 23); idle(2);
    chk("R8 clear", edh_err_o, 0);
  endtask

  task automatic t_force;
    int base;
    build(5'h0B, 5'h13, 5'h06);
    base = on;
    force_i = 1; send(0, 23); idle(3); force_i = 0;
    flags_are("R9 still captures input", 5'h0B, 5'h13, 5'h06);
    pk[12] = 10'h200; pk[13] = 10'h200; pk[14] = 10'h200;
    exp_cs = csum(22);
    chk("R9 anc word", ob[base + 12], 10'h200);
    chk("R9 ap word", ob[base + 13], 10'h200);
    chk("R9 ff word", ob[base + 14], 10'h200);
    chk("R11 crc word kept", ob[base + 6], 10'h2AA);
    chk("R10 forced checksum", ob[base + 22], exp_cs);
    build(5'h0B, 5'h13, 5'h06);
    base = on;
    send(0, 23); idle(3);
    chk("R10 checksum passes", ob[base + 22], pk[22]);
    chk("R11 flag word passes", ob[base + 12], pk[12]);
  endtask

  task automatic t_latency;
    word(10'h155);
    @(negedge clk_i); valid_i = 0;
    chk("R11 data", data_o, 10'h155); chk("R11 valid", valid_o, 1);
    @(negedge clk_i);
    chk("R11 valid drop", valid_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 t_reset;
    #30 rst_ni = 1;
    idle(2);
    t_basic; t_no_adf; t_trunc; t_disable; t_summary; t_force; t_latency;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule